// File: doc/BRIEF.md
# Byte-Wide Host Command/Status Mailbox

This block lets an external host controller exchange 16-bit words with an internal processor over an 8-bit bidirectional bus. The host sends a command word as two byte writes. Each write is marked by the rising edge of an active-low write strobe, and a byte-select line picks the lane: low selects bits 7:0 and high selects bits 15:8. Writing the upper byte completes the word. The block then presents the assembled 16 bits internally with a single-cycle valid pulse.

In the other direction, the internal side posts 16-bit status words. An active-low request output tells the host that a word is waiting. The host reads the word byte by byte with an active-low read strobe and the same byte select. The request clears only once the upper byte has been read. A second word posted before the first is read is held in a one-deep pending slot and is promoted after that upper-byte read.

The host strobes, the byte select and the bus are brought into the internal clock domain through a two-stage synchroniser. Edges are detected after synchronisation. The host must hold data and byte select stable for at least four internal clock cycles after a strobe returns high.

Top module: `host_mailbox`

## Requirements
- R1: After reset, `host_req_n` is 1, `cmd_valid` is 0, `sts_ready` is 1 and the block does not drive `host_bus`.
- R2: Writing a lower byte (`host_hi_sel`=0) and then an upper byte (`host_hi_sel`=1) produces `cmd_word` = {upper, lower}, with `cmd_valid` high for exactly one clock.
- R3: A lower-byte write on its own never raises `cmd_valid`.
- R4: An upper-byte write with no lower-byte write since the last completed word reuses the most recently written lower byte.
- R5: While `host_rd_n` is 1 the block leaves `host_bus` undriven. While it is 0 the block drives bits 7:0 of the current status word when `host_hi_sel`=0, and bits 15:8 when it is 1.
- R6: When `sts_post` is sampled high with no word waiting, `host_req_n` goes low on the following clock.
- R7: Reading only the lower status byte leaves `host_req_n` low. Completing a read of the upper byte raises `host_req_n` when no second word is pending.
- R8: A word posted while another is still unread goes to the pending slot, and `sts_ready` drops. After the upper byte of the current word is read, the pending word becomes current, `host_req_n` stays low and `sts_ready` returns to 1.
- R9: A post made while `sts_ready` is 0 is discarded and changes neither stored word.
- R10: A completed read when no word is waiting leaves `host_req_n` high and `sts_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| host_bus | inout | 8 | Bidirectional host data byte |
| host_wr_n | input | 1 | Host write strobe, active low; the byte is taken on its rising edge |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_hi_sel | input | 1 | Byte select: 0 = bits 7:0, 1 = bits 15:8 |
| host_req_n | output | 1 | Low while a status word waits for the host |
| cmd_word | output | 16 | Last completed command word |
| cmd_valid | output | 1 | One-cycle pulse when `cmd_word` is updated |
| sts_word | input | 16 | Status word to post |
| sts_post | input | 1 | Post `sts_word` this cycle |
| sts_ready | output | 1 | Pending slot free; a post is accepted |

## Verification
Command traffic is tried three ways: a normal lower-then-upper pair, a lone lower byte, and a lone upper byte after an earlier pair. Together these separate word assembly, premature completion and stale-lane reuse. Status traffic is tried as a single post with a lower-only read, then an upper read. This shows that only the upper byte releases the request. A back-to-back double post followed by a third post shows pending promotion, and that a post into a full slot is dropped. A read with nothing waiting, and bus reads with the strobe inactive, confirm that idle accesses change nothing and that the block never contends for the bus.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
    localparam int BYTE_W      = 8;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // synchronised host-side controls
    typedef struct packed {
        logic wr_n;
        logic rd_n;
        logic sel;
    } host_ctl_t;

    localparam host_ctl_t CTL_IDLE = '{wr_n: 1'b1, rd_n: 1'b1, sel: 1'b0};

    typedef struct packed {
        logic wr_done;
        logic rd_done;
        lane_e lane;
    } host_evt_t;

    function automatic lane_e to_lane(input logic sel);
        return sel ? LANE_HI : LANE_LO;
    endfunction
endpackage

// File: rtl/hmb_sync.sv
module hmb_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= din;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hmb_cmd_asm.sv
module hmb_cmd_asm
    import hmb_pkg::*;
#(
    parameter int BW = 8,
    localparam int WW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst,
    input  host_evt_t     evt,
    input  logic [BW-1:0] data,
    output logic [WW-1:0] cmd_word,
    output logic          cmd_valid
);
    logic [BW-1:0] lo_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold   <= '0;
            cmd_word  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (evt.wr_done) begin
                if (evt.lane == LANE_LO) begin
                    lo_hold <= data;
                end else begin
                    cmd_word  <= {data, lo_hold};
                    cmd_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hmb_sts_queue.sv
module hmb_sts_queue
    import hmb_pkg::*;
#(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  host_evt_t     evt,
    input  logic          post,
    input  logic [WW-1:0] word_in,
    output logic          cur_valid,
    output logic [WW-1:0] cur_word,
    output logic          ready
);
    logic          pend_valid;
    logic [WW-1:0] pend_word;
    logic          accept;
    logic          release_cur;

    assign ready       = !pend_valid;
    assign accept      = post && !pend_valid;
    assign release_cur = evt.rd_done && (evt.lane == LANE_HI) && cur_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_valid  <= 1'b0;
            cur_word   <= '0;
            pend_valid <= 1'b0;
            pend_word  <= '0;
        end else if (release_cur) begin
            if (pend_valid) begin
                cur_word   <= pend_word;
                pend_valid <= 1'b0;
            end else if (accept) begin
                cur_word <= word_in;
            end else begin
                cur_valid <= 1'b0;
            end
        end else if (accept) begin
            if (!cur_valid) begin
                cur_word  <= word_in;
                cur_valid <= 1'b1;
            end else begin
                pend_word  <= word_in;
                pend_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
    import hmb_pkg::*;
#(
    parameter int BW     = hmb_pkg::BYTE_W,
    parameter int STAGES = hmb_pkg::SYNC_DEPTH,
    localparam int WW    = 2 * BW
) (
    input  logic          clk,
    input  logic          rst,
    inout  wire  [BW-1:0] host_bus,
    input  logic          host_wr_n,
    input  logic          host_rd_n,
    input  logic          host_hi_sel,
    output logic          host_req_n,
    output logic [WW-1:0] cmd_word,
    output logic          cmd_valid,
    input  logic [WW-1:0] sts_word,
    input  logic          sts_post,
    output logic          sts_ready
);
    host_ctl_t     ctl_raw, ctl_s, ctl_prev;
    host_evt_t     evt;
    logic [BW-1:0] data_s;
    logic          cur_valid;
    logic [WW-1:0] cur_word;
    logic          bus_oe;
    logic [BW-1:0] bus_byte;

    assign ctl_raw = '{wr_n: host_wr_n, rd_n: host_rd_n, sel: host_hi_sel};

    hmb_sync #(.W($bits(host_ctl_t)), .STAGES(STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst(rst), .din(ctl_raw), .dout(ctl_s)
    );

    hmb_sync #(.W(BW), .STAGES(STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst(rst), .din(host_bus), .dout(data_s)
    );

    always_ff @(posedge clk) begin
        if (rst) ctl_prev <= CTL_IDLE;
        else     ctl_prev <= ctl_s;
    end

    always_comb begin
        evt.wr_done = ctl_s.wr_n && !ctl_prev.wr_n;
        evt.rd_done = ctl_s.rd_n && !ctl_prev.rd_n;
        evt.lane    = to_lane(ctl_s.sel);
    end

    hmb_cmd_asm #(.BW(BW)) u_cmd (
        .clk(clk), .rst(rst), .evt(evt), .data(data_s),
        .cmd_word(cmd_word), .cmd_valid(cmd_valid)
    );

    hmb_sts_queue #(.WW(WW)) u_sts (
        .clk(clk), .rst(rst), .evt(evt), .post(sts_post), .word_in(sts_word),
        .cur_valid(cur_valid), .cur_word(cur_word), .ready(sts_ready)
    );

    assign host_req_n = !cur_valid;
    assign bus_oe     = !host_rd_n;
    assign bus_byte   = host_hi_sel ? cur_word[WW-1:BW] : cur_word[BW-1:0];
    assign host_bus   = bus_oe ? bus_byte : {BW{1'bz}};
endmodule

// File: rtl/host_mailbox_chk.sv
module host_mailbox_chk (
    input logic clk,
    input logic rst,
    input logic host_rd_n,
    input logic host_req_n,
    input logic bus_oe,
    input logic cmd_valid,
    input logic sts_post,
    input logic sts_ready
);
    a_r2_valid_single: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    a_r5_no_drive_idle: assert property (@(posedge clk) disable iff (rst)
        host_rd_n |-> !bus_oe);

    a_r6_post_raises_req: assert property (@(posedge clk) disable iff (rst)
        (sts_post && host_req_n) |=> !host_req_n);

    a_r8_pending_needs_current: assert property (@(posedge clk) disable iff (rst)
        !sts_ready |-> !host_req_n);

    a_r8_ready_drop_needs_post: assert property (@(posedge clk) disable iff (rst)
        $fell(sts_ready) |-> $past(sts_post));
endmodule

bind host_mailbox host_mailbox_chk u_chk (
    .clk(clk), .rst(rst), .host_rd_n(host_rd_n), .host_req_n(host_req_n),
    .bus_oe(bus_oe), .cmd_valid(cmd_valid), .sts_post(sts_post), .sts_ready(sts_ready)
);

// File: tb/test_host_mailbox.sv
`timescale 1ns/1ps
module test_host_mailbox;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    wire  [7:0]  host_bus;
    logic        host_wr_n = 1'b1, host_rd_n = 1'b1, host_hi_sel = 1'b0;
    logic        host_req_n, cmd_valid, sts_ready;
    logic [15:0] cmd_word;
    logic [15:0] sts_word = '0;
    logic        sts_post = 1'b0;
    logic        tb_drv = 1'b0;
    logic [7:0]  tb_byte = '0;
    int          errors = 0, checks = 0;
    int          vcount = 0;
    logic [15:0] vword = '0;

    always #10 clk = ~clk;
    assign host_bus = tb_drv ? tb_byte : 8'hzz;

    host_mailbox i_host_mailbox (
        .clk(clk), .rst(rst), .host_bus(host_bus), .host_wr_n(host_wr_n),
        .host_rd_n(host_rd_n), .host_hi_sel(host_hi_sel), .host_req_n(host_req_n),
        .cmd_word(cmd_word), .cmd_valid(cmd_valid), .sts_word(sts_word),
        .sts_post(sts_post), .sts_ready(sts_ready)
    );

    // count valid pulses and remember last word
    always @(negedge clk) if (!rst && cmd_valid) begin
        vcount = vcount + 1;
        vword  = cmd_word;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(input logic hi, input logic [7:0] b);
        @(negedge clk);
        host_hi_sel = hi; tb_byte = b; tb_drv = 1'b1; host_wr_n = 1'b0;
        idle(2);
        host_wr_n = 1'b1;
        idle(6);
        tb_drv = 1'b0;
    endtask

    task automatic host_read(input logic hi, output logic [7:0] b);
        @(negedge clk);
        host_hi_sel = hi; host_rd_n = 1'b0;
        idle(2);
        b = host_bus;
        host_rd_n = 1'b1;
        idle(6);
    endtask

    task automatic post(input logic [15:0] w);
        @(negedge clk);
        sts_word = w; sts_post = 1'b1;
        @(negedge clk);
        sts_post = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 req_n", host_req_n, 1);
        check("R1 cmd_valid", cmd_valid, 0);
        check("R1 sts_ready", sts_ready, 1);
        tb_byte = 8'h5A; tb_drv = 1'b1; idle(1);
        check("R1 bus undriven", host_bus, 8'h5A);
        tb_drv = 1'b0;
    endtask

    task automatic t_cmd_pair;
        int c0;
        c0 = vcount;
        host_write(1'b0, 8'h34);
        check("R3 lone low no valid", vcount - c0, 0);
        host_write(1'b1, 8'h12);
        check("R2 one pulse", vcount - c0, 1);
        check("R2 word", vword, 16'h1234);
        c0 = vcount;
        host_write(1'b0, 8'hCD);
        host_write(1'b1, 8'hAB);
        check("R2 second word", vword, 16'hABCD);
        check("R2 second pulse", vcount - c0, 1);
    endtask

    task automatic t_cmd_reuse;
        int c0;
        c0 = vcount;
        host_write(1'b1, 8'h77);
        check("R4 reuse pulse", vcount - c0, 1);
        check("R4 reuse low", vword, 16'h77CD);
    endtask

    task automatic t_single_status;
        logic [7:0] b;
        post(16'hBEEF);
        check("R6 req low", host_req_n, 0);
        tb_byte = 8'h11; tb_drv = 1'b1; idle(1);
        check("R5 idle bus not driven", host_bus, 8'h11);
        tb_drv = 1'b0;
        host_read(1'b0, b);
        check("R5 low byte", b, 8'hEF);
        check("R7 low read keeps req", host_req_n, 0);
        host_read(1'b1, b);
        check("R5 high byte", b, 8'hBE);
        check("R7 high read clears req", host_req_n, 1);
    endtask

    task automatic t_pending;
        logic [7:0] b;
        post(16'h1111);
        post(16'h2222);
        check("R8 ready low", sts_ready, 0);
        post(16'h3333);
        check("R9 still one current", host_req_n, 0);
        host_read(1'b1, b);
        check("R8 first word hi", b, 8'h11);
        check("R8 req stays low", host_req_n, 0);
        check("R8 ready back", sts_ready, 1);
        host_read(1'b0, b);
        check("R9 promoted is second lo", b, 8'h22);
        host_read(1'b1, b);
        check("R9 promoted is second hi", b, 8'h22);
        check("R9 no third word", host_req_n, 1);
    endtask

    task automatic t_empty_read;
        logic [7:0] b;
        host_read(1'b1, b);
        check("R10 req stays high", host_req_n, 1);
        check("R10 ready stays high", sts_ready, 1);
    endtask

    initial begin
        fork
            begin
                idle(3);
                rst = 1'b0;
                idle(2);
                t_reset();
                t_cmd_pair();
                t_cmd_reuse();
                t_single_status();
                t_pending();
                t_empty_read();
            end
            begin
                idle(20000);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule